// File: doc/BRIEF.md
# Parallel Port Strobe and Data Interface

This block is the printer-facing data path of a parallel port. A CPU writes a byte to one address and the block latches it onto eight output data lines. Reading the same address returns a status byte built from the printer's busy, paper-out, select, fault and acknowledge inputs. These inputs pass through a synchronizer before they are reported.

A second bus select reaches a small control register. One control bit chooses how the strobe is made. In automatic mode every data write produces a timed strobe pulse, with one of two widths. In manual mode the strobe line simply follows a control bit. A further control bit drives the input-prime line. The pulse widths come from a clock-frequency parameter, so the same block can be used at any core clock.

Top module: `pport_strobe_if`

## Requirements
- R1: A data write (`bus_we`=1, `bus_ctl_sel`=0) latches `bus_wdata` onto `prn_data` at that clock edge. A read of the same select returns the status byte, not the data.
- R2: Status byte layout: bit 3 busy, bit 4 paper-out, bit 5 select, bit 6 fault, bit 7 acknowledge. Bits 2:0 always read 0.
- R3: Each printer input appears in the status byte exactly `SYNC_STAGES` clock edges after it changes, and not before.
- R4: In automatic mode (control bit 0 = 0), a data write raises `prn_strobe` one cycle after the write edge. The data lines are already valid by then.
- R5: With control bit 1 = 0, the automatic strobe stays high for `CLK_KHZ*64/10000` cycles (6.4 µs; 1600 cycles at the default 250 MHz).
- R6: With control bit 1 = 1, the automatic strobe stays high for `CLK_KHZ*16/10000` cycles (1.6 µs; 400 cycles at the default).
- R7: `prn_data` does not change while an automatic strobe is high, unless a new data write arrives.
- R8: A data write during an active automatic strobe updates `prn_data` and drops the strobe for one cycle. A fresh full-width pulse then follows.
- R9: In manual mode (control bit 0 = 1), `prn_strobe` equals control bit 2. Data writes still latch data but start no pulse.
- R10: `prn_prime` equals control bit 3 from the edge after the control write.
- R11: A control read (`bus_ctl_sel`=1) returns control bits 3:0, with bits 7:4 reading 0. Reset clears the control register and `prn_data`, and leaves the strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ctl_sel | input | 1 | 1 selects the control register, 0 selects data/status |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (status or control), combinational |
| prn_data | output | 8 | Latched printer data lines |
| prn_strobe | output | 1 | Data strobe, high = asserted |
| prn_prime | output | 1 | Input-prime line, high = asserted |
| prn_busy | input | 1 | Printer busy, asynchronous |
| prn_paper_out | input | 1 | Paper empty, asynchronous |
| prn_select | input | 1 | Printer selected, asynchronous |
| prn_fault | input | 1 | Printer fault, asynchronous |
| prn_ack | input | 1 | Acknowledge, asynchronous |

## Verification
On every cycle, the embedded properties check four things:
- the data lines hold still under a running automatic pulse;
- a data write cuts the automatic strobe in the following cycle;
- every completed automatic pulse has one of the two legal widths;
- input-prime tracks the last control write.

Only the directed scenarios can show the following:
- which width each control setting yields;
- the exact synchronizer latency and the bit positions of the status byte;
- the full pulse after a restart;
- manual-mode strobe behaviour and control readback.

// File: rtl/pport_pkg.sv
package pport_pkg;

   // control register bit positions (software visible)
   localparam int unsigned CTL_MANUAL_BIT = 0;
   localparam int unsigned CTL_FAST_BIT   = 1;
   localparam int unsigned CTL_LEVEL_BIT  = 2;
   localparam int unsigned CTL_PRIME_BIT  = 3;

   // status byte bit positions
   localparam int unsigned ST_BUSY_BIT  = 3;
   localparam int unsigned ST_PAPER_BIT = 4;
   localparam int unsigned ST_SEL_BIT   = 5;
   localparam int unsigned ST_FAULT_BIT = 6;
   localparam int unsigned ST_ACK_BIT   = 7;

   localparam int unsigned NUM_PRN_IN = 5;

   typedef struct packed {
      logic prime;
      logic level;
      logic fast;
      logic manual;
   } pport_ctl_t;

endpackage

// File: rtl/pport_ctl_reg.sv
module pport_ctl_reg
   import pport_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_byte,
   output pport_ctl_t ctl
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else if (wr_en) begin
         ctl.manual <= wr_byte[CTL_MANUAL_BIT];
         ctl.fast   <= wr_byte[CTL_FAST_BIT];
         ctl.level  <= wr_byte[CTL_LEVEL_BIT];
         ctl.prime  <= wr_byte[CTL_PRIME_BIT];
      end
   end

   // R10: prime bit follows the last control write
   p_prime_follow_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ctl.prime == $past(wr_byte[CTL_PRIME_BIT])));

endmodule

// File: rtl/pport_in_sync.sv
module pport_in_sync #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pport_in_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pport_in_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= '0;
         end else begin
            chain[s] <= (s == 0) ? async_in : chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/pport_strobe_gen.sv
module pport_strobe_gen #(
   parameter int unsigned LONG_CYC  = 1600,
   parameter int unsigned SHORT_CYC = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic manual,
   input  logic fast,
   input  logic man_level,
   output logic strobe
);

   localparam int unsigned CW = $clog2(LONG_CYC + 1);

   if (SHORT_CYC < 1 || SHORT_CYC > LONG_CYC) begin : g_bad_width
      $error("pport_strobe_gen: need 1 <= SHORT_CYC <= LONG_CYC");
   end

   logic          pend_q;
   logic [CW-1:0] cnt_q;
   logic          auto_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (manual) begin
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (fire) begin
         pend_q <= 1'b1;
         cnt_q  <= '0;
      end else if (pend_q) begin
         pend_q <= 1'b0;
         cnt_q  <= fast ? CW'(SHORT_CYC) : CW'(LONG_CYC);
      end else if (cnt_q != '0) begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign auto_on = (cnt_q != '0);
   assign strobe  = manual ? man_level : auto_on;

   // checker: length of the current automatic high run
   logic [CW:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_q <= '0;
      else if (auto_on) run_q <= run_q + 1'b1;
      else              run_q <= '0;
   end

   // R8: a write in auto mode cuts the strobe in the next cycle
   p_write_cuts_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !manual) |=> !auto_on);

   // R4: the automatic strobe only rises after a pending write
   p_rise_after_write_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(auto_on) |-> $past(pend_q));

   // R5 / R6: an uninterrupted pulse has one of the two legal widths
   p_width_legal_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(auto_on) && !$past(fire) && !$past(manual))
         |-> (run_q == (CW+1)'(LONG_CYC) || run_q == (CW+1)'(SHORT_CYC)));

   // R6: the run never exceeds the long width
   p_no_overrun_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= (CW+1)'(LONG_CYC));

endmodule

// File: rtl/pport_strobe_if.sv
module pport_strobe_if
   import pport_pkg::*;
#(
   parameter int unsigned CLK_KHZ     = 250_000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_ctl_sel,
   input  logic       bus_we,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic [7:0] prn_data,
   output logic       prn_strobe,
   output logic       prn_prime,
   input  logic       prn_busy,
   input  logic       prn_paper_out,
   input  logic       prn_select,
   input  logic       prn_fault,
   input  logic       prn_ack
);

   localparam int unsigned LONG_CYC  = (CLK_KHZ * 64) / 10000;
   localparam int unsigned SHORT_CYC = (CLK_KHZ * 16) / 10000;

   if (SHORT_CYC < 1) begin : g_bad_clk
      $error("pport_strobe_if: CLK_KHZ too low for the short strobe");
   end

   pport_ctl_t            ctl;
   logic                  data_wr;
   logic                  ctl_wr;
   logic [NUM_PRN_IN-1:0] raw_in;
   logic [NUM_PRN_IN-1:0] syn_in;

   assign data_wr = bus_we && !bus_ctl_sel;
   assign ctl_wr  = bus_we &&  bus_ctl_sel;

   // data latch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prn_data <= '0;
      else if (data_wr) prn_data <= bus_wdata;
   end

   pport_ctl_reg u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ctl_wr),
      .wr_byte (bus_wdata),
      .ctl     (ctl)
   );

   assign raw_in = {prn_ack, prn_fault, prn_select, prn_paper_out, prn_busy};

   pport_in_sync #(
      .WIDTH  (NUM_PRN_IN),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (raw_in),
      .sync_out (syn_in)
   );

   pport_strobe_gen #(
      .LONG_CYC  (LONG_CYC),
      .SHORT_CYC (SHORT_CYC)
   ) u_stb (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (data_wr),
      .manual    (ctl.manual),
      .fast      (ctl.fast),
      .man_level (ctl.level),
      .strobe    (prn_strobe)
   );

   assign prn_prime = ctl.prime;

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_ctl_sel) begin
         bus_rdata[CTL_MANUAL_BIT] = ctl.manual;
         bus_rdata[CTL_FAST_BIT]   = ctl.fast;
         bus_rdata[CTL_LEVEL_BIT]  = ctl.level;
         bus_rdata[CTL_PRIME_BIT]  = ctl.prime;
      end else begin
         bus_rdata[ST_BUSY_BIT]  = syn_in[0];
         bus_rdata[ST_PAPER_BIT] = syn_in[1];
         bus_rdata[ST_SEL_BIT]   = syn_in[2];
         bus_rdata[ST_FAULT_BIT] = syn_in[3];
         bus_rdata[ST_ACK_BIT]   = syn_in[4];
      end
   end

   // R7: data lines hold under a running automatic strobe
   p_data_stable_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (prn_strobe && $past(prn_strobe) && !ctl.manual && !$past(ctl.manual))
         |-> $stable(prn_data));

endmodule

// File: tb/pport_strobe_if_tb_top.sv
`timescale 1ns/1ps
module pport_strobe_if_tb_top;

   localparam int unsigned CLK_KHZ = 250_000;
   localparam int unsigned SYNC    = 2;
   localparam int unsigned LONG_W  = 1600;
   localparam int unsigned SHORT_W = 400;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_ctl_sel = 1'b0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] prn_data;
   logic       prn_strobe, prn_prime;
   logic       prn_busy = 0, prn_paper_out = 0, prn_select = 0;
   logic       prn_fault = 0, prn_ack = 0;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   pport_strobe_if #(.CLK_KHZ(CLK_KHZ), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_ctl_sel(bus_ctl_sel), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .prn_data(prn_data),
      .prn_strobe(prn_strobe), .prn_prime(prn_prime), .prn_busy(prn_busy),
      .prn_paper_out(prn_paper_out), .prn_select(prn_select),
      .prn_fault(prn_fault), .prn_ack(prn_ack));

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic sel, input logic [7:0] d);
      @(negedge clk);
      bus_ctl_sel = sel; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_ctl_sel = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [7:0] v);
      bus_ctl_sel = sel;
      #0.1;
      v = bus_rdata;
      bus_ctl_sel = 1'b0;
   endtask

   // counts consecutive high strobe cycles, sampled at negedges
   task automatic measure(output int w, output int dchg);
      logic [7:0] d0;
      w = 0; dchg = 0;
      @(negedge clk);
      d0 = prn_data;
      while (prn_strobe && w < 5000) begin
         w++;
         if (prn_data != d0) dchg++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(1'b1, v);
      check("R11 reset ctl", v, 0);
      check("R11 reset data", prn_data, 0);
      check("R11 reset strobe", prn_strobe, 0);
      check("R10 reset prime", prn_prime, 0);
   endtask

   task automatic t_long();
      int w, dc;
      logic [7:0] v;
      bus_write(1'b0, 8'hA5);
      check("R1 data latched", prn_data, 8'hA5);
      check("R4 strobe not yet high", prn_strobe, 0);
      rd(1'b0, v);
      check("R1 same address reads status", v, 0);
      measure(w, dc);
      check("R5 long width", w, LONG_W);
      check("R7 data stable", dc, 0);
   endtask

   task automatic t_short();
      int w, dc;
      bus_write(1'b1, 8'h02);
      bus_write(1'b0, 8'h3C);
      check("R4 strobe after write", prn_strobe, 0);
      measure(w, dc);
      check("R6 short width", w, SHORT_W);
      check("R1 data 3C", prn_data, 8'h3C);
      bus_write(1'b1, 8'h00);
   endtask

   task automatic t_restart();
      int w, dc;
      bus_write(1'b0, 8'h11);
      repeat (100) @(negedge clk);
      check("R8 strobe high mid pulse", prn_strobe, 1);
      bus_write(1'b0, 8'h22);
      check("R8 strobe cut", prn_strobe, 0);
      check("R8 data updated", prn_data, 8'h22);
      measure(w, dc);
      check("R8 full new pulse", w, LONG_W);
   endtask

   task automatic t_manual();
      logic [7:0] v;
      bus_write(1'b1, 8'h01);
      bus_write(1'b0, 8'h77);
      check("R9 data latched manual", prn_data, 8'h77);
      repeat (5) @(negedge clk);
      check("R9 no auto pulse", prn_strobe, 0);
      bus_write(1'b1, 8'hF5);
      check("R9 strobe follows level", prn_strobe, 1);
      rd(1'b1, v);
      check("R11 ctl readback", v, 8'h05);
      bus_write(1'b1, 8'h09);
      check("R9 strobe level low", prn_strobe, 0);
      check("R10 prime set", prn_prime, 1);
      bus_write(1'b1, 8'h00);
      check("R10 prime clear", prn_prime, 0);
   endtask

   task automatic t_status();
      logic [7:0] v;
      @(negedge clk);
      prn_busy = 1; prn_select = 1; prn_ack = 1;
      repeat (SYNC - 1) @(negedge clk);
      rd(1'b0, v);
      check("R3 not yet visible", v, 0);
      @(negedge clk);
      rd(1'b0, v);
      check("R2 R3 status a", v, 8'hA8);
      prn_busy = 0; prn_select = 0; prn_ack = 0;
      prn_paper_out = 1; prn_fault = 1;
      repeat (SYNC) @(negedge clk);
      rd(1'b0, v);
      check("R2 status b", v, 8'h50);
   endtask

   initial begin : watchdog
      repeat (100_000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_long();
      t_short();
      t_restart();
      t_manual();
      t_status();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule